// File: doc/BRIEF.md
# Serial Slave Front End with Pause Control

This block is the serial side of a small register-based peripheral. A host frames each transaction by pulling an active-low select line low. It then clocks bits in on the rising edge of the serial clock and reads bits back that change on the falling edge. All pins are oversampled by a faster system clock through two-flop synchronisers, and every edge is detected in the system clock domain.

Each completed group of eight received bits appears on a parallel byte output with a one-cycle valid strobe. The command layer preloads the next byte to transmit through a load strobe. Start and end of each transaction are reported as single-cycle pulses.

An active-low pause input lets the host stop in the middle of a byte without losing its place. The pause engages and releases only while the serial clock is low. While it is paused, the output is released and clock edges are not counted.

Top module: `spi_hold_slave`

## Requirements
- R1: Serial input is sampled on each counted rising serial-clock edge, most-significant bit first; after the eighth counted rise the assembled byte appears on `rx_byte_o` with `rx_valid_o` high for exactly one system clock.
- R2: While select is high, `miso_oe_o` is low and no byte is delivered.
- R3: `miso_o` presents the byte latched by `tx_load_i`, most-significant bit first. Its first bit is valid once select falls, and it advances one bit on each counted falling serial-clock edge. The falling edge that follows a completed byte brings out the most-significant bit of the currently latched byte.
- R4: A falling edge of select clears the bit position, so bits of a byte abandoned by a select rise never combine with bits of a later transaction.
- R5: `txn_start_o` pulses for one system clock on each falling edge of select.
- R6: The pause engages only when the pause input is low while the serial clock is low; while paused, `miso_oe_o` is low.
- R7: While paused, serial-clock edges are ignored: no bits are counted and `miso_o` does not advance. The pause releases only when the pause input is high while the serial clock is low.
- R8: `txn_end_o` pulses for one system clock on each rising edge of select.
- R9: A pin edge acts on the outputs at the third system clock edge after it: `rx_valid_o` is still low after the second edge following the eighth serial-clock rise and is high after the third.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock, faster than the serial clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| sclk_i | input | 1 | Serial clock from the host (idles low) |
| cs_n_i | input | 1 | Active-low transaction select |
| mosi_i | input | 1 | Serial data from the host |
| hold_n_i | input | 1 | Active-low pause request |
| miso_o | output | 1 | Serial data to the host |
| miso_oe_o | output | 1 | Output enable for `miso_o`; low means high impedance |
| rx_byte_o | output | DATA_W | Last complete received byte |
| rx_valid_o | output | 1 | One-cycle strobe for a new `rx_byte_o` |
| tx_byte_i | input | DATA_W | Next byte to transmit |
| tx_load_i | input | 1 | Latches `tx_byte_i` as the next byte to transmit |
| txn_start_o | output | 1 | One-cycle pulse on select falling |
| txn_end_o | output | 1 | One-cycle pulse on select rising |

## Verification
A wrong bit position shows up as a byte strobe arriving one bit early or late, with a shifted value, at the next byte boundary. A stuck or missed pause shows as `miso_oe_o` differing from the reference three system clocks after the pause pin changes. It also shows as a corrupted byte when the host resumes. Transmit errors appear on `miso_o` within one serial-clock half period, because the bench compares every output against its reference model on every system clock.

// File: rtl/shs_pkg.sv
package shs_pkg;

  // Synchronised view of the serial pins, most significant field first.
  typedef struct packed {
    logic sclk;
    logic cs_n;
    logic mosi;
    logic hold_n;
  } pins_t;

  // Pause state for the next cycle: engage and release both need a low clock.
  function automatic logic hold_next(input logic paused, input logic hold_n, input logic sclk);
    if (!paused) return !hold_n && !sclk;
    return !(hold_n && !sclk);
  endfunction

  // True when the bit now being received completes a byte of width w.
  function automatic logic last_bit(input int unsigned cnt, input int unsigned w);
    return cnt == (w - 1);
  endfunction

endpackage

// File: rtl/shs_sync.sv
module shs_sync #(
  parameter int unsigned W        = 4,
  parameter int unsigned STAGES   = 2,
  parameter logic [W-1:0] RST_VAL = '0
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [STAGES-1:0][W-1:0] stg;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < STAGES; i++) stg[i] <= RST_VAL;
    end else begin
      stg[0] <= d;
      for (int i = 1; i < STAGES; i++) stg[i] <= stg[i-1];
    end
  end

  assign q = stg[STAGES-1];
endmodule

// File: rtl/shs_rx.sv
module shs_rx import shs_pkg::*; #(
  parameter int unsigned DATA_W = 8,
  localparam int unsigned CW    = (DATA_W > 1) ? $clog2(DATA_W) : 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              clr,
  input  logic              shift_en,
  input  logic              din,
  output logic [CW-1:0]     bit_cnt,
  output logic [DATA_W-1:0] byte_o,
  output logic              valid_o
);
  logic [DATA_W-1:0] sh;
  logic [DATA_W-1:0] sh_next;
  logic              done;

  assign sh_next = {sh[DATA_W-2:0], din};
  assign done    = last_bit(32'(bit_cnt), DATA_W);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sh      <= '0;
      bit_cnt <= '0;
      byte_o  <= '0;
      valid_o <= 1'b0;
    end else begin
      valid_o <= 1'b0;
      if (clr) begin
        bit_cnt <= '0;
      end else if (shift_en) begin
        sh <= sh_next;
        if (done) begin
          bit_cnt <= '0;
          byte_o  <= sh_next;
          valid_o <= 1'b1;
        end else begin
          bit_cnt <= bit_cnt + 1'b1;
        end
      end
    end
  end

  // R1
  byte_wrap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    valid_o |-> (bit_cnt == '0));

  // R1
  valid_src_chk: assert property (@(posedge clk) disable iff (!rst_n)
    valid_o |-> $past(shift_en));
endmodule

// File: rtl/shs_tx.sv
module shs_tx #(
  parameter int unsigned DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load_en,
  input  logic [DATA_W-1:0] load_byte,
  input  logic              reload,
  input  logic              shift_en,
  output logic              dout
);
  logic [DATA_W-1:0] next_r;
  logic [DATA_W-1:0] sh;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      next_r <= '0;
      sh     <= '0;
    end else begin
      if (load_en) next_r <= load_byte;
      if (reload)        sh <= next_r;
      else if (shift_en) sh <= {sh[DATA_W-2:0], 1'b0};
    end
  end

  assign dout = sh[DATA_W-1];

  // R3
  miso_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!$past(reload) && !$past(shift_en)) |-> $stable(dout));
endmodule

// File: rtl/spi_hold_slave.sv
module spi_hold_slave import shs_pkg::*; #(
  parameter int unsigned DATA_W      = 8,
  parameter int unsigned SYNC_STAGES = 2,
  localparam int unsigned CW         = (DATA_W > 1) ? $clog2(DATA_W) : 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              sclk_i,
  input  logic              cs_n_i,
  input  logic              mosi_i,
  input  logic              hold_n_i,
  output logic              miso_o,
  output logic              miso_oe_o,
  output logic [DATA_W-1:0] rx_byte_o,
  output logic              rx_valid_o,
  input  logic [DATA_W-1:0] tx_byte_i,
  input  logic              tx_load_i,
  output logic              txn_start_o,
  output logic              txn_end_o
);
  localparam pins_t PIN_IDLE = '{sclk: 1'b0, cs_n: 1'b1, mosi: 1'b0, hold_n: 1'b1};

  pins_t raw;
  pins_t s;

  assign raw = '{sclk: sclk_i, cs_n: cs_n_i, mosi: mosi_i, hold_n: hold_n_i};

  shs_sync #(.W($bits(pins_t)), .STAGES(SYNC_STAGES), .RST_VAL(PIN_IDLE)) u_sync (
    .clk  (clk),
    .rst_n(rst_n),
    .d    (raw),
    .q    (s)
  );

  // Named internal events
  logic          sclk_q, cs_act_q, paused_q;
  logic          cs_act, cs_fall_ev, cs_rise_ev, live;
  logic          rise_ev, fall_ev, at_boundary;
  logic          tx_reload, tx_shift, rx_clr;
  logic [CW-1:0] bit_cnt;

  assign cs_act      = !s.cs_n;
  assign cs_fall_ev  = cs_act && !cs_act_q;
  assign cs_rise_ev  = !cs_act && cs_act_q;
  assign live        = cs_act && cs_act_q && !paused_q;
  assign rise_ev     = live && s.sclk && !sclk_q;
  assign fall_ev     = live && !s.sclk && sclk_q;
  assign at_boundary = (bit_cnt == '0);
  assign rx_clr      = cs_fall_ev || !cs_act;
  assign tx_reload   = cs_fall_ev || (fall_ev && at_boundary);
  assign tx_shift    = fall_ev && !at_boundary;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sclk_q      <= 1'b0;
      cs_act_q    <= 1'b0;
      paused_q    <= 1'b0;
      txn_start_o <= 1'b0;
      txn_end_o   <= 1'b0;
    end else begin
      sclk_q      <= s.sclk;
      cs_act_q    <= cs_act;
      paused_q    <= cs_act ? hold_next(paused_q, s.hold_n, s.sclk) : 1'b0;
      txn_start_o <= cs_fall_ev;
      txn_end_o   <= cs_rise_ev;
    end
  end

  assign miso_oe_o = cs_act_q && !paused_q;

  shs_rx #(.DATA_W(DATA_W)) u_rx (
    .clk     (clk),
    .rst_n   (rst_n),
    .clr     (rx_clr),
    .shift_en(rise_ev),
    .din     (s.mosi),
    .bit_cnt (bit_cnt),
    .byte_o  (rx_byte_o),
    .valid_o (rx_valid_o)
  );

  shs_tx #(.DATA_W(DATA_W)) u_tx (
    .clk      (clk),
    .rst_n    (rst_n),
    .load_en  (tx_load_i),
    .load_byte(tx_byte_i),
    .reload   (tx_reload),
    .shift_en (tx_shift),
    .dout     (miso_o)
  );

  // R2
  idle_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !cs_act_q |-> !rx_valid_o);

  // R6
  hold_low_clk_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(paused_q) |-> !$past(s.sclk));

  // R7
  pause_freeze_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(paused_q) && cs_act_q) |-> $stable(bit_cnt));

  // R5
  start_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    txn_start_o |-> (bit_cnt == '0));

  // R8
  end_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    txn_end_o |-> (!miso_oe_o && bit_cnt == '0));
endmodule

// File: tb/tb_spi_hold_slave.sv
module tb_spi_hold_slave;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       sclk = 1'b0, cs_n = 1'b1, mosi = 1'b0, hold_n = 1'b1;
  logic       miso, miso_oe, rx_valid, txn_start, txn_end, tx_load = 1'b0;
  logic [7:0] rx_byte, tx_byte = 8'h00;

  always #10 clk = ~clk;  // 50 MHz

  spi_hold_slave dut (
    .clk(clk), .rst_n(rst_n), .sclk_i(sclk), .cs_n_i(cs_n), .mosi_i(mosi), .hold_n_i(hold_n),
    .miso_o(miso), .miso_oe_o(miso_oe), .rx_byte_o(rx_byte), .rx_valid_o(rx_valid),
    .tx_byte_i(tx_byte), .tx_load_i(tx_load), .txn_start_o(txn_start), .txn_end_o(txn_end)
  );

  int errors = 0;
  int checks = 0;
  int cyc = 0;
  bit run = 1'b0;

  task automatic chk(input bit ok, input string req, input string what, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual=%0h expected=%0h at cycle %0d", req, what, act, exp, cyc);
    end
  endtask

  // Behavioural reference: pins seen two clocks late, then transaction state.
  bit [3:0] h1 = 4'b0101, h2 = 4'b0101;  // {sclk, cs_n, mosi, hold_n}
  bit m_act = 0, m_sck = 0, m_pause = 0;
  int m_bits = 0, m_txidx = 0;
  bit [7:0] m_rx = 0, m_txcur = 0, m_txnext = 0, e_byte = 0;
  bit e_valid = 0, e_start = 0, e_end = 0;

  always @(posedge clk) begin
    bit sck, act, hd, di, wasact, waspause, wassck;
    if (!rst_n) begin
      h1 = 4'b0101; h2 = 4'b0101; m_act = 0; m_sck = 0; m_pause = 0; m_bits = 0;
      m_txidx = 0; m_rx = 0; m_txcur = 0; m_txnext = 0; e_byte = 0;
      e_valid = 0; e_start = 0; e_end = 0;
    end else begin
      sck = h2[3]; act = !h2[2]; di = h2[1]; hd = h2[0];
      wasact = m_act; waspause = m_pause; wassck = m_sck;
      e_valid = 0; e_start = 0; e_end = 0;
      if (act && !wasact) begin
        e_start = 1; m_bits = 0; m_txcur = m_txnext; m_txidx = 0;
      end
      if (!act && wasact) e_end = 1;
      if (!act) m_bits = 0;
      if (act && wasact && !waspause) begin
        if (sck && !wassck) begin
          m_rx = {m_rx[6:0], di};
          m_bits++;
          if (m_bits == 8) begin e_valid = 1; e_byte = m_rx; m_bits = 0; end
        end
        if (!sck && wassck) begin
          if (m_bits == 0) begin m_txcur = m_txnext; m_txidx = 0; end
          else m_txidx++;
        end
      end
      if (!act) m_pause = 0;
      else if (!waspause) m_pause = !hd && !sck;
      else if (hd && !sck) m_pause = 0;
      if (tx_load) m_txnext = tx_byte;
      m_act = act; m_sck = sck;
      h2 = h1; h1 = {sclk, cs_n, mosi, hold_n};
    end
  end

  // Every-cycle comparison against the reference (R1..R8)
  always @(negedge clk) begin
    bit exp_oe, exp_bit;
    if (rst_n && run) begin
      exp_oe  = m_act && !m_pause;
      exp_bit = (m_txidx < 8) ? m_txcur[7 - m_txidx] : 1'b0;
      chk(miso_oe == exp_oe, "R2/R6", "miso_oe_o", miso_oe, exp_oe);
      if (exp_oe) chk(miso == exp_bit, "R3", "miso_o", miso, exp_bit);
      chk(rx_valid == e_valid, "R1", "rx_valid_o", rx_valid, e_valid);
      if (e_valid) chk(rx_byte == e_byte, "R1", "rx_byte_o", rx_byte, e_byte);
      chk(txn_start == e_start, "R5", "txn_start_o", txn_start, e_start);
      chk(txn_end == e_end, "R8", "txn_end_o", txn_end, e_end);
    end
  end

  // Received-byte log compared with what the host sent
  bit [7:0] got_q[$];
  bit [7:0] exp_q[$];
  always @(negedge clk) if (rst_n && rx_valid) got_q.push_back(rx_byte);

  task automatic tick(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic load_tx(input bit [7:0] v);
    tx_byte = v; tx_load = 1'b1; tick(1); tx_load = 1'b0;
  endtask

  task automatic sel(input bit on);
    if (on) begin cs_n = 1'b0; tick(6); end
    else begin tick(4); cs_n = 1'b1; tick(6); end
  endtask

  // Host sends bits hi..lo of v; miso checked against ob; lat adds the R9 timing probe.
  task automatic send_bits(input bit [7:0] v, input bit [7:0] ob, input int hi, input int lo, input bit lat);
    for (int i = hi; i >= lo; i--) begin
      mosi = v[i];
      tick(4);
      chk(miso == ob[i], "R3", "miso_o bit before rise", miso, ob[i]);
      sclk = 1'b1;
      if (lat && i == 0) begin
        tick(2);
        chk(rx_valid == 1'b0, "R9", "rx_valid_o two clocks after rise", rx_valid, 0);
        tick(1);
        chk(rx_valid == 1'b1, "R9", "rx_valid_o three clocks after rise", rx_valid, 1);
        tick(1);
      end else tick(4);
      sclk = 1'b0;
    end
  endtask

  task automatic check_rx(input string req);
    chk(got_q.size() == exp_q.size(), req, "received byte count", got_q.size(), exp_q.size());
    while (exp_q.size() > 0 && got_q.size() > 0) begin
      bit [7:0] g, e;
      g = got_q.pop_front(); e = exp_q.pop_front();
      chk(g == e, req, "received byte value", g, e);
    end
    got_q.delete(); exp_q.delete();
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc == 150000) begin
      errors++; checks++;
      $display("FAIL R1 watchdog: actual cycles=%0d expected below %0d", cyc, 150000);
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    tick(4);
    rst_n = 1'b1;
    tick(2);
    run = 1'b1;
    // R2 reset / idle state
    chk(miso_oe == 1'b0, "R2", "miso_oe_o after reset", miso_oe, 0);
    chk(rx_valid == 1'b0, "R2", "rx_valid_o after reset", rx_valid, 0);
    chk(txn_start == 1'b0 && txn_end == 1'b0, "R5", "pulses after reset", txn_start, 0);

    // Two bytes each way, with R9 latency probe on the first
    load_tx(8'h3C);
    sel(1);
    chk(miso_oe == 1'b1, "R2", "miso_oe_o when selected", miso_oe, 1);
    send_bits(8'hA5, 8'h3C, 7, 4, 0);
    load_tx(8'h81);
    send_bits(8'hA5, 8'h3C, 3, 0, 1);
    send_bits(8'h5A, 8'h81, 7, 0, 0);
    exp_q.push_back(8'hA5); exp_q.push_back(8'h5A);
    sel(0);
    chk(miso_oe == 1'b0, "R2", "miso_oe_o after deselect", miso_oe, 0);
    check_rx("R1");

    // R4 abandoned partial byte
    load_tx(8'hF0);
    sel(1);
    send_bits(8'hE0, 8'hF0, 7, 5, 0);
    sel(0);
    sel(1);
    send_bits(8'hC3, 8'hF0, 7, 0, 0);
    exp_q.push_back(8'hC3);
    sel(0);
    check_rx("R4");

    // R6/R7 pause with clock low, clock toggled while paused
    load_tx(8'h96);
    sel(1);
    send_bits(8'hB4, 8'h96, 7, 5, 0);
    hold_n = 1'b0; tick(4);
    chk(miso_oe == 1'b0, "R6", "miso_oe_o while paused", miso_oe, 0);
    for (int k = 0; k < 2; k++) begin
      mosi = ~mosi; sclk = 1'b1; tick(4); sclk = 1'b0; tick(4);
    end
    chk(miso_oe == 1'b0, "R7", "miso_oe_o still paused after clocks", miso_oe, 0);
    hold_n = 1'b1; tick(4);
    chk(miso_oe == 1'b1, "R7", "miso_oe_o after release", miso_oe, 1);
    send_bits(8'hB4, 8'h96, 4, 0, 0);
    exp_q.push_back(8'hB4);
    sel(0);
    check_rx("R7");

    // R6/R7 pause requested with clock high, release attempted with clock high
    load_tx(8'h2B);
    sel(1);
    send_bits(8'h6D, 8'h2B, 7, 6, 0);
    mosi = 1'b1; tick(4);
    sclk = 1'b1; hold_n = 1'b0; tick(4);
    chk(miso_oe == 1'b1, "R6", "no pause while clock high", miso_oe, 1);
    sclk = 1'b0; tick(4);
    chk(miso_oe == 1'b0, "R6", "pause once clock low", miso_oe, 0);
    sclk = 1'b1; hold_n = 1'b1; tick(4);
    chk(miso_oe == 1'b0, "R7", "no release while clock high", miso_oe, 0);
    sclk = 1'b0; tick(4);
    chk(miso_oe == 1'b1, "R7", "release once clock low", miso_oe, 1);
    send_bits(8'h6D, 8'h2B, 4, 0, 0);
    exp_q.push_back(8'h6D);
    sel(0);
    check_rx("R6");

    tick(4);
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule